// File: doc/BRIEF.md
# Effective Address and Stack Pointer Unit

This block forms 32-bit memory addresses for a small integer register machine. An indirect operand is built from up to three parts: a base register value, an index register value multiplied by a scale, and a constant displacement. Each part has its own presence bit, and a part that is absent adds zero. The same unit also drives the stack pointer for the four stack operations. Push and call move the pointer down one word and store at the new location. Pop and return load at the current location and then move the pointer up one word.

The unit is purely combinational. An operation code picks what it does, and all outputs settle in the same cycle as the inputs. It flags illegal addressing in three cases: the stack-pointer register used as the index, a scale outside the legal set, or a word-misaligned access. It leaves memory access, label resolution and register storage to the blocks around it.

Top module: `eau_top`

## Requirements
- R1: For opCode 2 (memory operand) and opCode 1 (address-only), effAddr equals (baseEn ? baseVal : 0) + (indexEn ? indexVal*scale : 0) + disp, modulo 2^32.
- R2: When indexEn is 1 and indexSel is 4 (the stack-pointer register) with opCode 1 or 2, fault is 1. The same indexSel with indexEn at 0 raises no fault.
- R3: When indexEn is 1 with opCode 1 or 2, a scale other than 1, 2, 4 or 8 sets fault to 1 and the index term counts as zero. When indexEn is 0, the scale value has no effect.
- R4: For opCode 2, an effAddr with either of its low two bits set raises fault. For opCode 1, the address is never checked for alignment.
- R5: For opCode 3 (push) and opCode 5 (call), newSp equals espVal - 4, effAddr equals that new value, and spWrEn is 1 when there is no fault.
- R6: For opCode 4 (pop) and opCode 6 (return), effAddr equals espVal and newSp equals espVal + 4. Index, base and scale inputs are ignored.
- R7: For a stack operation (opCode 3 to 6) whose store or load address is not word aligned, fault is 1 and spWrEn is 0.
- R8: For opCode 0 (idle), opCode 1, opCode 2 and opCode 7, spWrEn is 0 and newSp equals espVal.
- R9: memAccess is 1 for opCode 2 to 6 and 0 for opCode 0, 1 and 7. Opcode 1 returns the address as data only.
- R10: For opCode 0 or 7, effAddr is 0 and fault is 0.
- R11: Stack arithmetic wraps modulo 2^32. A push at espVal 0 gives 0xFFFFFFFC, and a pop at 0xFFFFFFFC gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opCode | input | 3 | Operation: 0 idle, 1 address-only, 2 memory operand, 3 push, 4 pop, 5 call, 6 return, 7 idle |
| baseVal | input | 32 | Base register value |
| baseEn | input | 1 | Base component present |
| indexVal | input | 32 | Index register value |
| indexEn | input | 1 | Index component present |
| indexSel | input | 3 | Register number supplying the index |
| scale | input | 4 | Index multiplier |
| disp | input | 32 | Displacement constant |
| espVal | input | 32 | Current stack-pointer value |
| effAddr | output | 32 | Effective address |
| newSp | output | 32 | Updated stack-pointer value |
| spWrEn | output | 1 | Stack-pointer write enable |
| fault | output | 1 | Illegal addressing flag |
| memAccess | output | 1 | Operation touches memory |

## Verification
Every result of this unit is due in the cycle its inputs are applied, because no register sits between any input and any output. The driver changes inputs just after the rising edge of the bench clock and queues the expected outputs for that vector. The monitor pops one expected item at the next falling edge and compares all five outputs there, half a period after the inputs settled and before the next vector arrives. Corner vectors cover wrap-around at both ends of the address space, the stack-pointer index with and without its presence bit, an illegal scale on an unused index, and misaligned memory, address-only and stack cases.

// File: rtl/eau_pkg.sv
package eau_pkg;

  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_ADDR = 3'd1,
    OP_MEM  = 3'd2,
    OP_PUSH = 3'd3,
    OP_POP  = 3'd4,
    OP_CALL = 3'd5,
    OP_RET  = 3'd6,
    OP_SPARE = 3'd7
  } eauOp_e;

  typedef struct packed {
    logic formOperand;
    logic spDown;
    logic spUp;
    logic alignCheck;
    logic memAccess;
    logic spWrite;
  } eauStrobe_t;

endpackage

// File: rtl/eau_ctrl.sv
module eau_ctrl
  import eau_pkg::*;
(
  input  logic [2:0] opCode,
  output eauStrobe_t strobe
);

  eauOp_e op;
  assign op = eauOp_e'(opCode);

  always_comb begin
    strobe = '0;
    unique case (op)
      OP_ADDR: begin
        strobe.formOperand = 1'b1;
      end
      OP_MEM: begin
        strobe.formOperand = 1'b1;
        strobe.alignCheck  = 1'b1;
        strobe.memAccess   = 1'b1;
      end
      OP_PUSH, OP_CALL: begin
        strobe.spDown     = 1'b1;
        strobe.alignCheck = 1'b1;
        strobe.memAccess  = 1'b1;
        strobe.spWrite    = 1'b1;
      end
      OP_POP, OP_RET: begin
        strobe.spUp       = 1'b1;
        strobe.alignCheck = 1'b1;
        strobe.memAccess  = 1'b1;
        strobe.spWrite    = 1'b1;
      end
      default: strobe = '0;
    endcase
  end

endmodule

// File: rtl/eau_dpath.sv
module eau_dpath
  import eau_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 3,
  parameter int SCALE_W    = 4,
  parameter int SP_INDEX   = 4,
  parameter int WORD_BYTES = 4,
  parameter int N_SCALES   = 4
) (
  input  eauStrobe_t        strobe,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic              baseEn,
  input  logic [ADDR_W-1:0] indexVal,
  input  logic              indexEn,
  input  logic [IDX_W-1:0]  indexSel,
  input  logic [SCALE_W-1:0] scale,
  input  logic [ADDR_W-1:0] disp,
  input  logic [ADDR_W-1:0] espVal,
  output logic [ADDR_W-1:0] effAddr,
  output logic [ADDR_W-1:0] newSp,
  output logic              spWrEn,
  output logic              fault,
  output logic              memAccess
);

  localparam int ALIGN_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);
  localparam logic [IDX_W-1:0] SP_SEL = IDX_W'(SP_INDEX);

  logic [N_SCALES-1:0] scaleHit;
  logic [ADDR_W-1:0]   shifted [N_SCALES];
  logic [ADDR_W-1:0]   indexTerm;
  logic [ADDR_W-1:0]   baseTerm;
  logic [ADDR_W-1:0]   operandSum;
  logic [ADDR_W-1:0]   spBelow;
  logic [ADDR_W-1:0]   spAbove;
  logic                scaleBad;
  logic                espAsIndex;
  logic                misaligned;
  logic                operandFault;

  // One comparator and one fixed shifter per legal power-of-two scale
  for (genvar g = 0; g < N_SCALES; g++) begin : gScale
    assign scaleHit[g] = (scale == SCALE_W'(1 << g));
    assign shifted[g]  = indexVal << g;
  end

  always_comb begin
    indexTerm = '0;
    for (int k = 0; k < N_SCALES; k++) begin
      if (scaleHit[k]) indexTerm = indexTerm | shifted[k];
    end
    if (!indexEn) indexTerm = '0;
  end

  assign baseTerm   = baseEn ? baseVal : '0;
  assign operandSum = baseTerm + indexTerm + disp;
  assign spBelow    = espVal - STEP;
  assign spAbove    = espVal + STEP;

  always_comb begin
    if (strobe.spDown)           effAddr = spBelow;
    else if (strobe.spUp)        effAddr = espVal;
    else if (strobe.formOperand) effAddr = operandSum;
    else                         effAddr = '0;
  end

  always_comb begin
    if (strobe.spDown)    newSp = spBelow;
    else if (strobe.spUp) newSp = spAbove;
    else                  newSp = espVal;
  end

  assign scaleBad     = indexEn && !(|scaleHit);
  assign espAsIndex   = indexEn && (indexSel == SP_SEL);
  assign misaligned   = |effAddr[ALIGN_W-1:0];
  assign operandFault = strobe.formOperand && (scaleBad || espAsIndex);

  assign fault     = operandFault || (strobe.alignCheck && misaligned);
  assign spWrEn    = strobe.spWrite && !fault;
  assign memAccess = strobe.memAccess;

endmodule

// File: rtl/eau_top.sv
module eau_top
  import eau_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 3,
  parameter int SCALE_W    = 4,
  parameter int SP_INDEX   = 4,
  parameter int WORD_BYTES = 4
) (
  input  logic [2:0]         opCode,
  input  logic [ADDR_W-1:0]  baseVal,
  input  logic               baseEn,
  input  logic [ADDR_W-1:0]  indexVal,
  input  logic               indexEn,
  input  logic [IDX_W-1:0]   indexSel,
  input  logic [SCALE_W-1:0] scale,
  input  logic [ADDR_W-1:0]  disp,
  input  logic [ADDR_W-1:0]  espVal,
  output logic [ADDR_W-1:0]  effAddr,
  output logic [ADDR_W-1:0]  newSp,
  output logic               spWrEn,
  output logic               fault,
  output logic               memAccess
);

  eauStrobe_t strobe;

  eau_ctrl uCtrl (
    .opCode (opCode),
    .strobe (strobe)
  );

  eau_dpath #(
    .ADDR_W     (ADDR_W),
    .IDX_W      (IDX_W),
    .SCALE_W    (SCALE_W),
    .SP_INDEX   (SP_INDEX),
    .WORD_BYTES (WORD_BYTES),
    .N_SCALES   (4)
  ) uDpath (
    .strobe    (strobe),
    .baseVal   (baseVal),
    .baseEn    (baseEn),
    .indexVal  (indexVal),
    .indexEn   (indexEn),
    .indexSel  (indexSel),
    .scale     (scale),
    .disp      (disp),
    .espVal    (espVal),
    .effAddr   (effAddr),
    .newSp     (newSp),
    .spWrEn    (spWrEn),
    .fault     (fault),
    .memAccess (memAccess)
  );

endmodule

// File: rtl/eau_checker.sv
module eau_checker #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3
) (
  input logic [2:0]        opCode,
  input logic              indexEn,
  input logic [IDX_W-1:0]  indexSel,
  input logic [ADDR_W-1:0] espVal,
  input logic [ADDR_W-1:0] effAddr,
  input logic [ADDR_W-1:0] newSp,
  input logic              spWrEn,
  input logic              fault,
  input logic              memAccess
);

  logic isDown, isUp, isOperand, isStack;
  assign isDown    = (opCode == 3'd3) || (opCode == 3'd5);
  assign isUp      = (opCode == 3'd4) || (opCode == 3'd6);
  assign isOperand = (opCode == 3'd1) || (opCode == 3'd2);
  assign isStack   = isDown || isUp;

  always_comb begin
    assert_push_order_R5: assert (!isDown || (newSp == espVal - ADDR_W'(4) && effAddr == newSp));
    assert_pop_order_R6: assert (!isUp || (effAddr == espVal && newSp == espVal + ADDR_W'(4)));
    assert_sp_idle_R8: assert (isStack || (!spWrEn && newSp == espVal));
    assert_sp_index_R2: assert (!(isOperand && indexEn && indexSel == IDX_W'(4)) || fault);
    assert_misalign_R4: assert (!(opCode == 3'd2 && effAddr[1:0] != 2'b00) || fault);
    assert_fault_blocks_R7: assert (!fault || !spWrEn);
    assert_lea_no_mem_R9: assert (opCode != 3'd1 || !memAccess);
  end

endmodule

bind eau_top eau_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) chk (.*);

// File: tb/eau_top_test.sv
`timescale 1ns/1ps
module eau_top_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [2:0]  opCode = '0;
  logic [31:0] baseVal = '0, indexVal = '0, disp = '0, espVal = '0;
  logic        baseEn = 1'b0, indexEn = 1'b0;
  logic [2:0]  indexSel = '0;
  logic [3:0]  scale = '0;
  logic [31:0] effAddr, newSp;
  logic        spWrEn, fault, memAccess;

  eau_top uut (
    .opCode(opCode), .baseVal(baseVal), .baseEn(baseEn),
    .indexVal(indexVal), .indexEn(indexEn), .indexSel(indexSel),
    .scale(scale), .disp(disp), .espVal(espVal),
    .effAddr(effAddr), .newSp(newSp), .spWrEn(spWrEn),
    .fault(fault), .memAccess(memAccess)
  );

  typedef struct {
    string       tag;
    logic [31:0] ea;
    logic [31:0] sp;
    logic        wr;
    logic        f;
    logic        ma;
  } expItem_t;

  expItem_t sb[$];
  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;

  task automatic drive(input string tag, input logic [2:0] op,
                       input logic [31:0] b, input logic bE,
                       input logic [31:0] ix, input logic iE, input logic [2:0] sel,
                       input logic [3:0] sc, input logic [31:0] d, input logic [31:0] esp,
                       input logic [31:0] eEa, input logic [31:0] eSp,
                       input logic eWr, input logic eF, input logic eMa);
    expItem_t it;
    @(posedge clk);
    #1;
    opCode = op; baseVal = b; baseEn = bE; indexVal = ix; indexEn = iE;
    indexSel = sel; scale = sc; disp = d; espVal = esp;
    it.tag = tag; it.ea = eEa; it.sp = eSp; it.wr = eWr; it.f = eF; it.ma = eMa;
    sb.push_back(it);
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      expItem_t e;
      e = sb.pop_front();
      nVec++;
      if (effAddr !== e.ea || newSp !== e.sp || spWrEn !== e.wr ||
          fault !== e.f || memAccess !== e.ma) begin
        nBad++;
        $display("FAIL %s: got ea=%h sp=%h wr=%b f=%b ma=%b, expected ea=%h sp=%h wr=%b f=%b ma=%b",
                 e.tag, effAddr, newSp, spWrEn, fault, memAccess,
                 e.ea, e.sp, e.wr, e.f, e.ma);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: got no completion, expected end of vectors");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    // R10 R8: idle state after start, outputs quiet
    drive("R10 idle", 3'd0, 32'h0, 0, 32'h0, 0, 3'd0, 4'd0, 32'h0, 32'h1000,
          32'h0, 32'h1000, 0, 0, 0);
    // R1: all three parts present
    drive("R1 full operand", 3'd2, 32'h1000, 1, 32'd3, 1, 3'd1, 4'd4, 32'h10, 32'h1000,
          32'h101C, 32'h1000, 0, 0, 1);
    // R1: absent parts count zero
    drive("R1 disp only", 3'd2, 32'hDEAD0000, 0, 32'h1234, 0, 3'd2, 4'd8, 32'h2000, 32'h1000,
          32'h2000, 32'h1000, 0, 0, 1);
    // R3: scale 8 legal
    drive("R3 scale8", 3'd2, 32'h0, 1, 32'd2, 1, 3'd2, 4'd8, 32'h0, 32'h1000,
          32'h10, 32'h1000, 0, 0, 1);
    // R2: stack pointer as index
    drive("R2 sp index", 3'd2, 32'h100, 1, 32'd8, 1, 3'd4, 4'd1, 32'h0, 32'h1000,
          32'h108, 32'h1000, 0, 1, 1);
    // R2: sp select without presence bit
    drive("R2 sp unused", 3'd2, 32'h100, 1, 32'd8, 0, 3'd4, 4'd1, 32'h0, 32'h1000,
          32'h100, 32'h1000, 0, 0, 1);
    // R3: illegal scale, index term zero
    drive("R3 bad scale", 3'd2, 32'h40, 1, 32'd4, 1, 3'd1, 4'd3, 32'h0, 32'h1000,
          32'h40, 32'h1000, 0, 1, 1);
    // R3: illegal scale ignored when index absent
    drive("R3 scale ignored", 3'd2, 32'h40, 1, 32'd4, 0, 3'd1, 4'd5, 32'h0, 32'h1000,
          32'h40, 32'h1000, 0, 0, 1);
    // R4: misaligned memory operand
    drive("R4 misaligned mem", 3'd2, 32'h0, 0, 32'h0, 0, 3'd0, 4'd1, 32'h102, 32'h1000,
          32'h102, 32'h1000, 0, 1, 1);
    // R4 R9: address-only not checked, no memory access
    drive("R4 R9 addr-only", 3'd1, 32'h0, 0, 32'h0, 0, 3'd0, 4'd1, 32'h103, 32'h1000,
          32'h103, 32'h1000, 0, 0, 0);
    // R1: address wrap on address-only op
    drive("R1 wrap", 3'd1, 32'hFFFFFFF0, 1, 32'h0, 0, 3'd0, 4'd1, 32'h20, 32'h1000,
          32'h10, 32'h1000, 0, 0, 0);
    // R5: push
    drive("R5 push", 3'd3, 32'h0, 0, 32'h0, 0, 3'd0, 4'd1, 32'h0, 32'h1000,
          32'hFFC, 32'hFFC, 1, 0, 1);
    // R5: call
    drive("R5 call", 3'd5, 32'h0, 0, 32'h0, 0, 3'd0, 4'd1, 32'h0, 32'h2000,
          32'h1FFC, 32'h1FFC, 1, 0, 1);
    // R6: pop, index inputs ignored
    drive("R6 pop", 3'd4, 32'h55, 1, 32'd9, 1, 3'd4, 4'd3, 32'h7, 32'h1000,
          32'h1000, 32'h1004, 1, 0, 1);
    // R6 R11: return wraps up to zero
    drive("R6 R11 ret wrap", 3'd6, 32'h0, 0, 32'h0, 0, 3'd0, 4'd1, 32'h0, 32'hFFFFFFFC,
          32'hFFFFFFFC, 32'h0, 1, 0, 1);
    // R11: push wraps below zero
    drive("R11 push wrap", 3'd3, 32'h0, 0, 32'h0, 0, 3'd0, 4'd1, 32'h0, 32'h0,
          32'hFFFFFFFC, 32'hFFFFFFFC, 1, 0, 1);
    // R7: misaligned stack pointer blocks write
    drive("R7 misaligned sp", 3'd3, 32'h0, 0, 32'h0, 0, 3'd0, 4'd1, 32'h0, 32'h1002,
          32'hFFE, 32'hFFE, 0, 1, 1);
    // R7: misaligned pop
    drive("R7 misaligned pop", 3'd4, 32'h0, 0, 32'h0, 0, 3'd0, 4'd1, 32'h0, 32'h1001,
          32'h1001, 32'h1005, 0, 1, 1);
    // R8 R10: spare code acts idle
    drive("R8 R10 spare", 3'd7, 32'h40, 1, 32'h0, 0, 3'd0, 4'd1, 32'h4, 32'h3000,
          32'h0, 32'h3000, 0, 0, 0);
    // R8: memory op leaves stack pointer alone
    drive("R8 mem no sp", 3'd2, 32'h200, 1, 32'h0, 0, 3'd0, 4'd1, 32'h0, 32'h3000,
          32'h200, 32'h3000, 0, 0, 1);
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule